// File: doc/BRIEF.md
# Coprocessor Slave Bus Interface

This block is the slave side of a coprocessor handshake. The master steers every transfer with a 2-bit status code instead of an address. A code-11 write carries an ID byte. When that byte matches the block's own ID, the block claims the instruction. The first code-01 write after the claim is the operation word. Each further code-01 write is an operand word, collected into a buffer until the number of words named by the operation word has arrived.

After the last operand word, the block gives a one-cycle start to an execution core. When the core reports done, the block latches the core's error flag, compare flags and result words. It then drives a shared, pulled-up completion line low for a fixed number of cycles. The line is modelled as an output enable plus a data bit, and is released at all other times. The master then reads the status word with code 10, followed by the result words with code 01. A new code-11 write at any time drops the instruction in progress and starts decoding again.

Top module: `cpslv_top`

## Requirements
- R1: A code-11 write whose low 8 data bits equal SLAVE_ID (default 8'h1E) claims an instruction. A code-11 write with any other byte leaves the block unclaimed, and later code-01 writes then never produce core_start.
- R2: Once claimed, the first code-01 write is latched as the operation word and presented on core_opword.
- R3: The number of expected operand words comes from the operation word. Bits [1:0] give the operand count, and the value 3 is treated as 2. Bit 2 marks 64-bit operands, which take two words each. The word count is the operand count, shifted left by bit 2.
- R4: core_start is high for exactly one cycle. That cycle follows the write of the last expected operand word, or the operation word when no operands are expected. core_start is never high earlier.
- R5: Operand words are stored in arrival order: word k appears at core_operands[32k+31:32k].
- R6: When core_done arrives during execution, the completion line is driven low (cpl_oe=1, cpl_o=0) for exactly PULSE_LEN (default 2) cycles, starting the cycle after core_done. Otherwise cpl_oe is 0.
- R7: A code-10 read after completion returns the status word, and returns 0 before completion. Status word layout: bit 0 is Quit (the core's error), bit 6 is Z, bit 7 is N, and bit 2 (L) and all other bits are 0.
- R8: After the status read, code-01 reads return the result words in order. Reads past core_res_n words return 0.
- R9: A code-01 read before the status word has been read returns 0 and raises proto_err in the same cycle.
- R10: A code-11 write in any state aborts the current instruction. It clears the operand buffer, and the next status read returns 0 until a new completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Master write strobe |
| bus_rd | input | 1 | Master read strobe |
| bus_code | input | 2 | Transfer status code |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the read cycle |
| proto_err | output | 1 | Premature result read flag |
| core_start | output | 1 | One-cycle start to the execution core |
| core_opword | output | OPW_W | Latched operation word |
| core_operands | output | MAX_WORDS*DW | Operand word buffer |
| core_done | input | 1 | Core completion |
| core_err | input | 1 | Core error, becomes Quit |
| core_n | input | 1 | Compare N flag |
| core_z | input | 1 | Compare Z flag |
| core_res | input | RES_MAX*DW | Result words |
| core_res_n | input | RIDX_W | Number of valid result words |
| cpl_oe | output | 1 | Completion line drive enable |
| cpl_o | output | 1 | Completion line value when driven |

## Verification
The bench targets the boundaries of operand counting:
- A count of zero, where the operation word alone must start the core.
- 64-bit operands, where a design that ignores the size bit would start one word early.
- The count value 3, where a design without saturation would wait for a third word.

It aborts an instruction between operands. A design that kept its word counter or buffer across the abort would start at the wrong time or expose stale data. It also reads results before and after the status read, and past the last result, to catch a design that leaks data early or indexes beyond the valid words. Finally, it counts the cycles of the completion pulse exactly, to catch a pulse that is one cycle short or one cycle long.

// File: rtl/cpslv_pkg.sv
package cpslv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPW,
      ST_OPS,
      ST_EXEC,
      ST_STAT,
      ST_RES
   } cps_state_t;

   localparam logic [1:0] CODE_XFER = 2'b01;
   localparam logic [1:0] CODE_STAT = 2'b10;
   localparam logic [1:0] CODE_ID   = 2'b11;
endpackage

// File: rtl/cpslv_opdecode.sv
module cpslv_opdecode #(
   parameter int OPW_W = 16,
   parameter int CNT_W = 3
) (
   input  logic [OPW_W-1:0] opword,
   output logic [CNT_W-1:0] exp_words
);
   logic [1:0] cnt_eff;

   always_comb begin
      cnt_eff   = (opword[1:0] == 2'd3) ? 2'd2 : opword[1:0];
      exp_words = CNT_W'(cnt_eff) << opword[2];
   end

   logic unused_hi;
   assign unused_hi = ^opword[OPW_W-1:3];
endmodule

// File: rtl/cpslv_opbuf.sv
module cpslv_opbuf #(
   parameter int DW    = 32,
   parameter int WORDS = 4,
   localparam int IDX_W = $clog2(WORDS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                we,
   input  logic [IDX_W-1:0]    widx,
   input  logic [DW-1:0]       wdata,
   output logic [WORDS*DW-1:0] flat
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      logic [DW-1:0] word_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               word_r <= '0;
         else if (clr)                             word_r <= '0;
         else if (we && widx == IDX_W'(g))         word_r <= wdata;
      end
      assign flat[g*DW +: DW] = word_r;
   end
endmodule

// File: rtl/cpslv_cpl_pulse.sv
module cpslv_cpl_pulse #(
   parameter int PULSE_LEN = 2,
   localparam int CW = $clog2(PULSE_LEN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic oe
);
   logic [CW-1:0] left_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              left_r <= '0;
      else if (trig)           left_r <= CW'(PULSE_LEN);
      else if (left_r != '0)   left_r <= left_r - CW'(1);
   end

   assign oe = (left_r != '0);
endmodule

// File: rtl/cpslv_top.sv
module cpslv_top
   import cpslv_pkg::*;
#(
   parameter int           DW        = 32,
   parameter int           OPW_W     = 16,
   parameter int           ID_W      = 8,
   parameter logic [7:0]   SLAVE_ID  = 8'h1E,
   parameter int           MAX_WORDS = 4,
   parameter int           RES_MAX   = 2,
   parameter int           PULSE_LEN = 2,
   localparam int          WIDX_W    = $clog2(MAX_WORDS + 1),
   localparam int          BIDX_W    = $clog2(MAX_WORDS),
   localparam int          RIDX_W    = $clog2(RES_MAX + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic [1:0]              bus_code,
   input  logic [DW-1:0]           bus_wdata,
   output logic [DW-1:0]           bus_rdata,
   output logic                    proto_err,
   output logic                    core_start,
   output logic [OPW_W-1:0]        core_opword,
   output logic [MAX_WORDS*DW-1:0] core_operands,
   input  logic                    core_done,
   input  logic                    core_err,
   input  logic                    core_n,
   input  logic                    core_z,
   input  logic [RES_MAX*DW-1:0]   core_res,
   input  logic [RIDX_W-1:0]       core_res_n,
   output logic                    cpl_oe,
   output logic                    cpl_o
);
   if (DW < 8 || DW < OPW_W)      begin : g_bad_dw    $error("DW too narrow"); end
   if (ID_W > 8 || ID_W > DW)     begin : g_bad_id    $error("ID_W out of range"); end
   if (MAX_WORDS < 4)             begin : g_bad_words $error("MAX_WORDS below 4"); end
   if (OPW_W < 3)                 begin : g_bad_opw   $error("OPW_W below 3"); end
   if (RES_MAX < 1)               begin : g_bad_res   $error("RES_MAX below 1"); end
   if (PULSE_LEN < 1)             begin : g_bad_pulse $error("PULSE_LEN below 1"); end

   cps_state_t            st;
   logic [OPW_W-1:0]      opword_r;
   logic [WIDX_W-1:0]     op_cnt;
   logic [WIDX_W-1:0]     exp_words;
   logic [OPW_W-1:0]      dec_in;
   logic                  start_r;
   logic                  q_r, n_r, z_r;
   logic [RES_MAX*DW-1:0] res_r;
   logic [RIDX_W-1:0]     res_n_r;
   logic [RIDX_W-1:0]     res_idx;
   logic [DW-1:0]         stat_w;

   logic wr_id, id_hit, wr_x, rd_s, rd_x, pulse_trig;
   assign wr_id      = bus_wr && bus_code == CODE_ID;
   assign id_hit     = wr_id && bus_wdata[ID_W-1:0] == SLAVE_ID[ID_W-1:0];
   assign wr_x       = bus_wr && bus_code == CODE_XFER;
   assign rd_s       = bus_rd && bus_code == CODE_STAT;
   assign rd_x       = bus_rd && bus_code == CODE_XFER;
   assign pulse_trig = (st == ST_EXEC) && core_done && !wr_id;
   assign dec_in     = (st == ST_OPW) ? bus_wdata[OPW_W-1:0] : opword_r;

   cpslv_opdecode #(.OPW_W(OPW_W), .CNT_W(WIDX_W)) u_dec (
      .opword(dec_in), .exp_words(exp_words));

   cpslv_opbuf #(.DW(DW), .WORDS(MAX_WORDS)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(wr_id),
      .we(wr_x && st == ST_OPS), .widx(op_cnt[BIDX_W-1:0]),
      .wdata(bus_wdata), .flat(core_operands));

   cpslv_cpl_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(pulse_trig), .oe(cpl_oe));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         opword_r <= '0;
         op_cnt   <= '0;
         start_r  <= 1'b0;
         q_r      <= 1'b0;
         n_r      <= 1'b0;
         z_r      <= 1'b0;
         res_r    <= '0;
         res_n_r  <= '0;
         res_idx  <= '0;
      end else begin
         start_r <= 1'b0;
         if (wr_id) begin
            st     <= id_hit ? ST_OPW : ST_IDLE;
            op_cnt <= '0;
         end else begin
            case (st)
               ST_OPW: if (wr_x) begin
                  opword_r <= bus_wdata[OPW_W-1:0];
                  if (exp_words == '0) begin
                     st      <= ST_EXEC;
                     start_r <= 1'b1;
                  end else begin
                     st <= ST_OPS;
                  end
               end
               ST_OPS: if (wr_x) begin
                  op_cnt <= op_cnt + WIDX_W'(1);
                  if (op_cnt == exp_words - WIDX_W'(1)) begin
                     st      <= ST_EXEC;
                     start_r <= 1'b1;
                  end
               end
               ST_EXEC: if (core_done) begin
                  st      <= ST_STAT;
                  q_r     <= core_err;
                  n_r     <= core_n;
                  z_r     <= core_z;
                  res_r   <= core_res;
                  res_n_r <= core_res_n;
               end
               ST_STAT: if (rd_s) begin
                  st      <= ST_RES;
                  res_idx <= '0;
               end
               ST_RES: if (rd_x && res_idx < res_n_r) res_idx <= res_idx + RIDX_W'(1);
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      stat_w    = '0;
      stat_w[0] = q_r;
      stat_w[6] = z_r;
      stat_w[7] = n_r;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd_s && (st == ST_STAT || st == ST_RES))
         bus_rdata = stat_w;
      else if (rd_x && st == ST_RES && res_idx < res_n_r)
         bus_rdata = res_r[res_idx*DW +: DW];
   end

   assign proto_err   = rd_x && st != ST_RES;
   assign core_start  = start_r;
   assign core_opword = opword_r;
   assign cpl_o       = 1'b0;
endmodule

// File: rtl/cpslv_chk.sv
module cpslv_chk #(
   parameter int DW        = 32,
   parameter int PULSE_LEN = 2,
   localparam int RW       = $clog2(PULSE_LEN + 2)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_rd,
   input logic [1:0]    bus_code,
   input logic [DW-1:0] bus_rdata,
   input logic          proto_err,
   input logic          core_start,
   input logic          cpl_oe,
   input logic          cpl_o
);
   logic [RW-1:0] run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_cnt <= '0;
      else if (cpl_oe)  run_cnt <= run_cnt + RW'(1);
      else              run_cnt <= '0;
   end

   // R4
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

   // R6
   pulse_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_oe |-> run_cnt < RW'(PULSE_LEN));

   // R6
   pulse_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpl_oe) |-> run_cnt == RW'(PULSE_LEN));

   // R6
   line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpl_oe |-> !cpl_o);

   // R7
   lbit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_code == 2'b10) |-> !bus_rdata[2]);

   // R9
   early_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> (bus_rdata == '0 && bus_rd && bus_code == 2'b01));
endmodule

bind cpslv_top cpslv_chk #(.DW(DW), .PULSE_LEN(PULSE_LEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_code(bus_code),
   .bus_rdata(bus_rdata), .proto_err(proto_err), .core_start(core_start),
   .cpl_oe(cpl_oe), .cpl_o(cpl_o));

// File: tb/tb_cpslv_top.sv
module tb_cpslv_top;
   localparam int DW = 32;
   localparam int MW = 4;
   localparam int RM = 2;
   localparam logic [7:0] MY_ID = 8'h1E;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [1:0]    bus_code = 2'b00;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          proto_err, core_start, cpl_oe, cpl_o;
   logic [15:0]   core_opword;
   logic [MW*DW-1:0] core_operands;
   logic          core_done = 1'b0, core_err = 1'b0, core_n = 1'b0, core_z = 1'b0;
   logic [RM*DW-1:0] core_res = '0;
   logic [1:0]    core_res_n = '0;

   int checks = 0;
   int errors = 0;

   logic [32:0] exp_q[$];
   string       tag_q[$];

   always #4 clk = ~clk;

   cpslv_top dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_code(bus_code), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .proto_err(proto_err), .core_start(core_start), .core_opword(core_opword),
      .core_operands(core_operands), .core_done(core_done), .core_err(core_err),
      .core_n(core_n), .core_z(core_z), .core_res(core_res),
      .core_res_n(core_res_n), .cpl_oe(cpl_oe), .cpl_o(cpl_o));

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read items and compares
   always @(negedge clk) begin
      #2;
      if (bus_rd) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "scoreboard underflow", 64'(bus_rdata), 64'h0);
         end else begin
            logic [32:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk({proto_err, bus_rdata} == e, t, 64'({proto_err, bus_rdata}), 64'(e));
         end
      end
   end

   task automatic wr(input logic [1:0] c, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_code = c; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_code = 2'b00;
   endtask

   task automatic rd(input logic [1:0] c, input logic [31:0] e, input logic ep, input string tag);
      @(negedge clk);
      exp_q.push_back({ep, e});
      tag_q.push_back(tag);
      bus_rd = 1'b1; bus_code = c;
      @(negedge clk);
      bus_rd = 1'b0; bus_code = 2'b00;
   endtask

   task automatic exp_start(input logic e, input string tag);
      chk(core_start == e, tag, 64'(core_start), 64'(e));
   endtask

   task automatic finish_core(input logic err, input logic n, input logic z,
                              input logic [31:0] r0, input logic [31:0] r1,
                              input logic [1:0] rn);
      @(negedge clk);
      core_done = 1'b1; core_err = err; core_n = n; core_z = z;
      core_res = {r1, r0}; core_res_n = rn;
      @(negedge clk);
      core_done = 1'b0; core_err = 1'b0; core_n = 1'b0; core_z = 1'b0;
      core_res = '0; core_res_n = '0;
      chk(cpl_oe == 1'b1 && cpl_o == 1'b0, "R6 pulse cycle 1", 64'({cpl_oe, cpl_o}), 64'h2);
      @(negedge clk);
      chk(cpl_oe == 1'b1, "R6 pulse cycle 2", 64'(cpl_oe), 64'h1);
      @(negedge clk);
      chk(cpl_oe == 1'b0, "R6 line released", 64'(cpl_oe), 64'h0);
   endtask

   task automatic summary;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!cpl_oe && !core_start && !proto_err, "R6 R4 R9 reset state",
          64'({cpl_oe, core_start, proto_err}), 64'h0);

      // R1: wrong ID, no claim
      wr(2'b11, 32'h55);
      wr(2'b01, 32'h0000);
      exp_start(1'b0, "R1 foreign ID must not start");
      @(negedge clk);
      exp_start(1'b0, "R1 foreign ID must not start later");
      rd(2'b10, 32'h0, 1'b0, "R7 status before completion");

      // R2 R3 R4 R5: two single-word operands
      wr(2'b11, 32'(MY_ID));
      wr(2'b01, 32'h0A02);
      exp_start(1'b0, "R4 no start after opword");
      chk(core_opword == 16'h0A02, "R2 opword latched", 64'(core_opword), 64'h0A02);
      wr(2'b01, 32'hAAAA1111);
      exp_start(1'b0, "R4 no start after first operand");
      wr(2'b01, 32'hBBBB2222);
      exp_start(1'b1, "R4 start after last operand");
      chk(core_operands[63:0] == 64'hBBBB2222_AAAA1111, "R5 operand order",
          core_operands[63:0], 64'hBBBB2222_AAAA1111);
      @(negedge clk);
      exp_start(1'b0, "R4 start one cycle only");
      rd(2'b01, 32'h0, 1'b1, "R9 result read during execution");
      finish_core(1'b0, 1'b1, 1'b0, 32'hCAFE0001, 32'hCAFE0002, 2'd2);
      rd(2'b01, 32'h0, 1'b1, "R9 result read before status");
      rd(2'b10, 32'h80, 1'b0, "R7 status N set");
      rd(2'b01, 32'hCAFE0001, 1'b0, "R8 result word 0");
      rd(2'b01, 32'hCAFE0002, 1'b0, "R8 result word 1");
      rd(2'b01, 32'h0, 1'b0, "R8 read past results");

      // R3: one long operand = two words
      wr(2'b11, 32'(MY_ID));
      wr(2'b01, 32'h0005);
      wr(2'b01, 32'h01234567);
      exp_start(1'b0, "R3 long operand needs second word");
      wr(2'b01, 32'h89ABCDEF);
      exp_start(1'b1, "R3 start after second word of long operand");
      finish_core(1'b1, 1'b0, 1'b1, 32'h0, 32'h0, 2'd0);
      rd(2'b10, 32'h41, 1'b0, "R7 quit and Z");
      rd(2'b01, 32'h0, 1'b0, "R8 no result words");

      // R4: zero operands
      wr(2'b11, 32'(MY_ID));
      wr(2'b01, 32'h0000);
      exp_start(1'b1, "R4 start straight after opword");
      finish_core(1'b0, 1'b1, 1'b1, 32'h77, 32'h0, 2'd1);
      rd(2'b10, 32'hC0, 1'b0, "R7 N and Z");
      rd(2'b01, 32'h77, 1'b0, "R8 single result");

      // R3: count 3 saturates to 2
      wr(2'b11, 32'(MY_ID));
      wr(2'b01, 32'h0003);
      wr(2'b01, 32'h1);
      exp_start(1'b0, "R3 count3 after first word");
      wr(2'b01, 32'h2);
      exp_start(1'b1, "R3 count3 treated as two");

      // R10: abort between operands
      wr(2'b11, 32'(MY_ID));
      wr(2'b01, 32'h0002);
      wr(2'b01, 32'h11111111);
      exp_start(1'b0, "R10 before abort");
      wr(2'b11, 32'(MY_ID));
      chk(core_operands == '0, "R10 buffer cleared", core_operands[63:0], 64'h0);
      wr(2'b01, 32'h0001);
      wr(2'b01, 32'h22222222);
      exp_start(1'b1, "R10 restart counts from new opword");
      chk(core_operands[31:0] == 32'h22222222, "R10 new operand word 0",
          64'(core_operands[31:0]), 64'h22222222);
      finish_core(1'b1, 1'b1, 1'b1, 32'h0, 32'h0, 2'd0);
      wr(2'b11, 32'(MY_ID));
      rd(2'b10, 32'h0, 1'b0, "R10 status dropped by new ID");

      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained", 64'(exp_q.size()), 64'h0);
      summary();
   end
endmodule